// File: doc/BRIEF.md
# Double-Buffered BCD Real-Time Clock

This block is a byte-wide real-time clock mapped into the top eight locations of an 11-bit, SRAM-style address space. A 15-bit prescaler turns a one-cycle enable from a 32.768 kHz oscillator domain into a one-second event. A set of internal packed-BCD counters (seconds, minutes, 24-hour hours, weekday, date, month, two-digit year) counts on that event and is never stopped by software. The bus sees a separate bank of user registers. The bank follows the counters while it is idle. Two control bits change this. One bit freezes the bank so that software can read a consistent snapshot. The other bit holds the bank so that software can write new values, and clearing that bit moves them into the counters.

The bus is synchronous to `clk`. A write takes effect on a rising edge while the chip enable and write enable are both low. Read data is combinational, driven while the chip enable and output enable are low and the write enable is high. A stop bit in the seconds byte parks the prescaler and the counters. A test bit in the weekday byte replaces the seconds LSB on reads with a 512 Hz square wave taken from the prescaler.

Top module: `rtc_shadow_clock`

## Requirements
- R1: Register offsets within the top eight addresses (0x7F8 to 0x7FF) are 0 control, 1 seconds, 2 minutes, 3 hours, 4 weekday, 5 date, 6 month, 7 year. After reset they read 00,00,00,00,01,01,01,00. A read outside the window, or a read with `oe_n` high, returns 0x00.
- R2: One second passes every 2^PRESC_W accepted enables, and the seconds count in packed BCD (09 is followed by 10).
- R3: Seconds and minutes wrap from 59 to 00, and hours wrap from 23 to 00. The hour wrap advances the weekday, which runs 1 to 7 and then back to 1.
- R4: The date wraps after the last day of its month: 30 for months 04, 06, 09 and 11, 31 for the other long months, and for month 02 either 29 (when the year's value is divisible by 4, 00 included) or 28. Month 12 wraps to 01 and year 99 wraps to 00.
- R5: While control bit 6 (read freeze) is 1, the user registers keep the time they held at the edge that set the bit, and the internal counters keep advancing.
- R6: Once both control bits are 0, the user registers show the live count within two clock cycles.
- R7: While control bit 7 (write hold) is 1, the time fields accept writes, and those writes read back masked to the field widths: seconds and minutes 7 bits, hours and date 6, weekday 3, month 5, year 8. While bit 7 is 0, writes to the time fields are ignored.
- R8: A write that clears control bit 7 loads the user registers into the counters and zeroes the prescaler. The next second follows a full 2^PRESC_W enables later.
- R9: If the load and a one-second event fall in the same cycle, the load wins and the loaded time is not incremented.
- R10: Seconds bit 7 is the oscillator stop. It can be written at any time and reads back. While it is 1, the prescaler is held at zero and no time passes.
- R11: Weekday bit 6 is the frequency test bit. It can be written at any time and reads back. While it is 1 and the oscillator runs, seconds bit 0 reads prescaler bit PRESC_W-10, which toggles at 512 Hz with the default width. Otherwise bit 0 reads the seconds LSB.
- R12: Control reads return bit 7 as write hold, bit 6 as read freeze, and zeros in bits 5 to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick32k_en | input | 1 | One-cycle enable at the 32.768 kHz rate |
| addr | input | ADDR_W | Byte address |
| dq_in | input | 8 | Write data |
| dq_out | output | 8 | Read data, 0x00 when not reading the window |
| ce_n | input | 1 | Chip enable, active low |
| oe_n | input | 1 | Output enable, active low |
| we_n | input | 1 | Write enable, active low |

## Verification
The clear of the write-hold bit and a one-second event from the prescaler can happen in the same cycle. Both of them target the internal counters. The bench loads a time and then issues exactly 2^PRESC_W-1 further enables. It then drives the last enable in the same cycle as the control write that clears the hold. It judges the result by reading the loaded time back unchanged and by seeing the next second arrive only after a further full prescaler period.

// File: rtl/rtc_pkg.sv
package rtc_pkg;

  localparam int REG_CTRL = 0;
  localparam int REG_SEC  = 1;
  localparam int REG_MIN  = 2;
  localparam int REG_HOUR = 3;
  localparam int REG_DOW  = 4;
  localparam int REG_DATE = 5;
  localparam int REG_MON  = 6;
  localparam int REG_YEAR = 7;

  // Field order makes byte k of the packed value equal register offset k.
  typedef struct packed {
    logic [7:0] year;
    logic [7:0] mon;
    logic [7:0] date;
    logic [7:0] dow;
    logic [7:0] hour;
    logic [7:0] min;
    logic [7:0] sec;
  } rtc_time_t;

  localparam rtc_time_t RTC_RESET_TIME = '{year: 8'h00, mon: 8'h01, date: 8'h01,
                                           dow: 8'h01, hour: 8'h00, min: 8'h00,
                                           sec: 8'h00};

  function automatic logic [7:0] field_mask(input int idx);
    case (idx)
      REG_SEC, REG_MIN:   return 8'h7F;
      REG_HOUR, REG_DATE: return 8'h3F;
      REG_DOW:            return 8'h07;
      REG_MON:            return 8'h1F;
      default:            return 8'hFF;
    endcase
  endfunction

  function automatic logic [7:0] bcd_inc(input logic [7:0] v);
    if (v[3:0] >= 4'd9) return {v[7:4] + 4'd1, 4'd0};
    return v + 8'd1;
  endfunction

  function automatic int bcd_value(input logic [7:0] v);
    return int'(v[7:4]) * 10 + int'(v[3:0]);
  endfunction

  function automatic logic leap_year(input logic [7:0] y);
    return (bcd_value(y) % 4) == 0;
  endfunction

  function automatic logic [7:0] month_last(input logic [7:0] m, input logic [7:0] y);
    case (m)
      8'h02:                      return leap_year(y) ? 8'h29 : 8'h28;
      8'h04, 8'h06, 8'h09, 8'h11: return 8'h30;
      default:                    return 8'h31;
    endcase
  endfunction

  function automatic rtc_time_t advance(input rtc_time_t t);
    rtc_time_t n;
    n = t;
    if (t.sec != 8'h59) begin
      n.sec = bcd_inc(t.sec);
    end else begin
      n.sec = 8'h00;
      if (t.min != 8'h59) begin
        n.min = bcd_inc(t.min);
      end else begin
        n.min = 8'h00;
        if (t.hour != 8'h23) begin
          n.hour = bcd_inc(t.hour);
        end else begin
          n.hour = 8'h00;
          n.dow  = (t.dow >= 8'h07) ? 8'h01 : t.dow + 8'h01;
          if (t.date < month_last(t.mon, t.year)) begin
            n.date = bcd_inc(t.date);
          end else begin
            n.date = 8'h01;
            if (t.mon < 8'h12) begin
              n.mon = bcd_inc(t.mon);
            end else begin
              n.mon  = 8'h01;
              n.year = (t.year == 8'h99) ? 8'h00 : bcd_inc(t.year);
            end
          end
        end
      end
    end
    return n;
  endfunction

endpackage

// File: rtl/rtc_prescaler.sv
module rtc_prescaler #(
  parameter int PRESC_W = 15
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick_en,
  input  logic halt,
  input  logic restart,
  output logic sec_tick,
  output logic wave512
);
  localparam int TEST_BIT = PRESC_W - 10;

  logic [PRESC_W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (!rst_n)              cnt_q <= '0;
    else if (halt || restart) cnt_q <= '0;
    else if (tick_en)        cnt_q <= cnt_q + 1'b1;
  end

  // Raw event; the counter stage decides priority against a load.
  assign sec_tick = tick_en && !halt && (&cnt_q);
  assign wave512  = cnt_q[TEST_BIT];
endmodule

// File: rtl/rtc_time_counter.sv
module rtc_time_counter
  import rtc_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      sec_tick,
  input  logic      load,
  input  rtc_time_t load_val,
  output rtc_time_t now
);
  always_ff @(posedge clk) begin
    if (!rst_n)        now <= RTC_RESET_TIME;
    else if (load)     now <= load_val;
    else if (sec_tick) now <= advance(now);
  end
endmodule

// File: rtl/rtc_user_bank.sv
module rtc_user_bank
  import rtc_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       bus_wr,
  input  logic [2:0] sel,
  input  logic [7:0] wdata,
  input  rtc_time_t  live,
  input  logic       wave512,
  output rtc_time_t  shadow,
  output logic       ctrl_wr,
  output logic       ctrl_rd,
  output logic       osc_stop,
  output logic       ft_en,
  output logic       load_pulse,
  output logic [7:0] rdata
);
  localparam int NREG = 7;
  localparam logic [NREG:1][7:0] RESET_A = RTC_RESET_TIME;

  logic [NREG:1][7:0] live_a;
  logic [7:0]         shadow_u [1:NREG];
  logic               copy_en;
  logic               ctrl_hit;

  assign live_a     = live;
  assign copy_en    = !ctrl_wr && !ctrl_rd;
  assign ctrl_hit   = bus_wr && (sel == 3'(REG_CTRL));
  assign load_pulse = ctrl_hit && ctrl_wr && !wdata[7];

  generate
    for (genvar i = 1; i <= NREG; i++) begin : g_reg
      logic hit;
      assign hit = bus_wr && ctrl_wr && (sel == 3'(i));
      always_ff @(posedge clk) begin
        if (!rst_n)       shadow_u[i] <= RESET_A[i];
        else if (copy_en) shadow_u[i] <= live_a[i];
        else if (hit)     shadow_u[i] <= wdata & field_mask(i);
      end
    end
  endgenerate

  assign shadow = {shadow_u[7], shadow_u[6], shadow_u[5], shadow_u[4],
                   shadow_u[3], shadow_u[2], shadow_u[1]};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctrl_wr  <= 1'b0;
      ctrl_rd  <= 1'b0;
      osc_stop <= 1'b0;
      ft_en    <= 1'b0;
    end else begin
      if (ctrl_hit) begin
        ctrl_wr <= wdata[7];
        ctrl_rd <= wdata[6];
      end
      if (bus_wr && sel == 3'(REG_SEC)) osc_stop <= wdata[7];
      if (bus_wr && sel == 3'(REG_DOW)) ft_en    <= wdata[6];
    end
  end

  always_comb begin
    case (int'(sel))
      REG_CTRL: rdata = {ctrl_wr, ctrl_rd, 6'b0};
      REG_SEC:  rdata = {osc_stop, shadow.sec[6:1],
                         (ft_en && !osc_stop) ? wave512 : shadow.sec[0]};
      REG_MIN:  rdata = shadow.min;
      REG_HOUR: rdata = shadow.hour;
      REG_DOW:  rdata = {1'b0, ft_en, 3'b0, shadow.dow[2:0]};
      REG_DATE: rdata = shadow.date;
      REG_MON:  rdata = shadow.mon;
      default:  rdata = shadow.year;
    endcase
  end
endmodule

// File: rtl/rtc_shadow_clock.sv
module rtc_shadow_clock
  import rtc_pkg::*;
#(
  parameter int ADDR_W  = 11,
  parameter int PRESC_W = 15
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick32k_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [7:0]        dq_in,
  output logic [7:0]        dq_out,
  input  logic              ce_n,
  input  logic              oe_n,
  input  logic              we_n
);
  localparam int SEL_W = 3;

  logic       in_window, bus_wr, bus_rd;
  logic [SEL_W-1:0] sel;
  logic       sec_tick, wave512, load_pulse;
  logic       ctrl_wr, ctrl_rd, osc_stop, ft_en;
  logic [7:0] rdata;
  rtc_time_t  live_time, shadow_time;

  assign in_window = &addr[ADDR_W-1:SEL_W];
  assign sel       = addr[SEL_W-1:0];
  assign bus_wr    = in_window && !ce_n && !we_n;
  assign bus_rd    = in_window && !ce_n && !oe_n && we_n;
  assign dq_out    = bus_rd ? rdata : 8'h00;

  rtc_prescaler #(.PRESC_W(PRESC_W)) u_presc (
    .clk(clk), .rst_n(rst_n), .tick_en(tick32k_en), .halt(osc_stop),
    .restart(load_pulse), .sec_tick(sec_tick), .wave512(wave512)
  );

  rtc_time_counter u_count (
    .clk(clk), .rst_n(rst_n), .sec_tick(sec_tick), .load(load_pulse),
    .load_val(shadow_time), .now(live_time)
  );

  rtc_user_bank u_bank (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .sel(sel), .wdata(dq_in),
    .live(live_time), .wave512(wave512), .shadow(shadow_time),
    .ctrl_wr(ctrl_wr), .ctrl_rd(ctrl_rd), .osc_stop(osc_stop), .ft_en(ft_en),
    .load_pulse(load_pulse), .rdata(rdata)
  );
endmodule

// File: rtl/rtc_shadow_clock_chk.sv
module rtc_shadow_clock_chk
  import rtc_pkg::*;
(
  input logic      clk,
  input logic      rst_n,
  input logic      sec_tick,
  input logic      load_pulse,
  input logic      osc_stop,
  input logic      ctrl_wr,
  input logic      ctrl_rd,
  input rtc_time_t live_time,
  input rtc_time_t shadow_time
);
  // R10
  stop_no_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
    osc_stop |-> !sec_tick);

  // R2
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!sec_tick && !load_pulse) |=> $stable(live_time));

  // R2
  tick_moves_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sec_tick && !load_pulse) |=> live_time != $past(live_time));

  // R3
  sec_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sec_tick && !load_pulse && live_time.sec == 8'h59) |=> live_time.sec == 8'h00);

  // R5
  freeze_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_rd && !ctrl_wr) |=> $stable(shadow_time));

  // R6
  track_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!ctrl_rd && !ctrl_wr) |=> shadow_time == $past(live_time));

  // R8 R9
  load_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    load_pulse |=> live_time == $past(shadow_time));
endmodule

bind rtc_shadow_clock rtc_shadow_clock_chk u_chk (
  .clk(clk), .rst_n(rst_n), .sec_tick(sec_tick), .load_pulse(load_pulse),
  .osc_stop(osc_stop), .ctrl_wr(ctrl_wr), .ctrl_rd(ctrl_rd),
  .live_time(live_time), .shadow_time(shadow_time)
);

// File: tb/rtc_shadow_clock_bench.sv
module rtc_shadow_clock_bench;
  localparam int CLK_PERIOD = 10;
  localparam int PW         = 11;
  localparam int SECOND     = 1 << PW;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tick32k_en = 1'b0;
  logic [10:0] addr = '0;
  logic [7:0]  dq_in = '0;
  logic [7:0]  dq_out;
  logic        ce_n = 1'b1, oe_n = 1'b1, we_n = 1'b1;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  // bench model: binary time, BCD shadow
  int m_sec = 0, m_min = 0, m_hour = 0, m_dow = 1, m_date = 1, m_mon = 1, m_year = 0;
  int presc = 0;
  bit m_wr = 0, m_rd = 0, m_osc = 0, m_ft = 0;
  logic [7:0] sh [1:7] = '{8'h00, 8'h00, 8'h00, 8'h01, 8'h01, 8'h01, 8'h00};

  rtc_shadow_clock #(.ADDR_W(11), .PRESC_W(PW)) u_rtc_shadow_clock (
    .clk(clk), .rst_n(rst_n), .tick32k_en(tick32k_en), .addr(addr),
    .dq_in(dq_in), .dq_out(dq_out), .ce_n(ce_n), .oe_n(oe_n), .we_n(we_n)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic logic [7:0] to_bcd(input int v);
    return 8'(((v / 10) << 4) | (v % 10));
  endfunction

  function automatic int from_bcd(input logic [7:0] b);
    return int'(b[7:4]) * 10 + int'(b[3:0]);
  endfunction

  function automatic int days_of(input int mon, input int year);
    if (mon == 2) return (year % 4 == 0) ? 29 : 28;
    if (mon == 4 || mon == 6 || mon == 9 || mon == 11) return 30;
    return 31;
  endfunction

  function automatic logic [7:0] mask_of(input int idx);
    if (idx == 1 || idx == 2) return 8'h7F;
    if (idx == 3 || idx == 5) return 8'h3F;
    if (idx == 4) return 8'h07;
    if (idx == 6) return 8'h1F;
    return 8'hFF;
  endfunction

  function automatic logic [7:0] model_field(input int idx);
    case (idx)
      1: return to_bcd(m_sec);
      2: return to_bcd(m_min);
      3: return to_bcd(m_hour);
      4: return to_bcd(m_dow);
      5: return to_bcd(m_date);
      6: return to_bcd(m_mon);
      default: return to_bcd(m_year);
    endcase
  endfunction

  task automatic model_second();
    m_sec++;
    if (m_sec == 60) begin
      m_sec = 0; m_min++;
      if (m_min == 60) begin
        m_min = 0; m_hour++;
        if (m_hour == 24) begin
          m_hour = 0;
          m_dow = (m_dow == 7) ? 1 : m_dow + 1;
          m_date++;
          if (m_date > days_of(m_mon, m_year)) begin
            m_date = 1; m_mon++;
            if (m_mon == 13) begin m_mon = 1; m_year = (m_year + 1) % 100; end
          end
        end
      end
    end
  endtask

  task automatic model_edge(input bit en, input bit wr, input int sel, input logic [7:0] data);
    logic [7:0] old [1:7];
    bit ld;
    for (int i = 1; i <= 7; i++) old[i] = model_field(i);
    ld = wr && sel == 0 && m_wr && !data[7];
    if (ld) begin
      m_sec = from_bcd(sh[1]); m_min = from_bcd(sh[2]); m_hour = from_bcd(sh[3]);
      m_dow = from_bcd(sh[4]); m_date = from_bcd(sh[5]); m_mon = from_bcd(sh[6]);
      m_year = from_bcd(sh[7]); presc = 0;
    end else if (m_osc) begin
      presc = 0;
    end else if (en) begin
      if (presc == SECOND - 1) begin presc = 0; model_second(); end
      else presc++;
    end
    if (!m_wr && !m_rd) begin
      for (int i = 1; i <= 7; i++) sh[i] = old[i];
    end else if (m_wr && wr && sel != 0) begin
      sh[sel] = data & mask_of(sel);
    end
    if (wr && sel == 0) begin m_wr = data[7]; m_rd = data[6]; end
    if (wr && sel == 1) m_osc = data[7];
    if (wr && sel == 4) m_ft = data[6];
  endtask

  // Called just after a falling edge; returns just after the next one.
  task automatic cycle(input bit en, input bit wr, input int sel, input logic [7:0] data);
    tick32k_en = en;
    if (wr) begin
      addr = {8'hFF, 3'(sel)}; dq_in = data; ce_n = 1'b0; we_n = 1'b0;
    end
    @(posedge clk);
    model_edge(en, wr, sel, data);
    @(negedge clk);
    tick32k_en = 1'b0; ce_n = 1'b1; we_n = 1'b1;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) cycle(0, 0, 0, 8'h00);
  endtask

  task automatic run(input int n);
    for (int i = 0; i < n; i++) begin
      if ($urandom % 3 == 0) cycle(0, 0, 0, 8'h00);
      cycle(1, 0, 0, 8'h00);
    end
  endtask

  task automatic read_at(input logic [10:0] a, output logic [7:0] v);
    addr = a; ce_n = 1'b0; oe_n = 1'b0;
    #1;
    v = dq_out;
    ce_n = 1'b1; oe_n = 1'b1;
  endtask

  task automatic rd(input int sel, output logic [7:0] v);
    read_at({8'hFF, 3'(sel)}, v);
  endtask

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %02h expected %02h", tag, act, exp);
    end
  endtask

  task automatic check_time(input string tag);
    logic [7:0] v;
    rd(1, v); chk({tag, " sec"},  v, {m_osc, to_bcd(m_sec)[6:0]});
    rd(2, v); chk({tag, " min"},  v, to_bcd(m_min));
    rd(3, v); chk({tag, " hour"}, v, to_bcd(m_hour));
    rd(4, v); chk({tag, " dow"},  v, {1'b0, m_ft, 3'b0, to_bcd(m_dow)[2:0]});
    rd(5, v); chk({tag, " date"}, v, to_bcd(m_date));
    rd(6, v); chk({tag, " mon"},  v, to_bcd(m_mon));
    rd(7, v); chk({tag, " year"}, v, to_bcd(m_year));
  endtask

  task automatic write_fields(input int y, input int mo, input int d, input int dw,
                              input int h, input int mi, input int s);
    cycle(0, 1, 1, {m_osc, to_bcd(s)[6:0]});
    cycle(0, 1, 2, to_bcd(mi));
    cycle(0, 1, 3, to_bcd(h));
    cycle(0, 1, 4, {1'b0, m_ft, 3'b0, to_bcd(dw)[2:0]});
    cycle(0, 1, 5, to_bcd(d));
    cycle(0, 1, 6, to_bcd(mo));
    cycle(0, 1, 7, to_bcd(y));
  endtask

  task automatic set_time(input int y, input int mo, input int d, input int dw,
                          input int h, input int mi, input int s);
    cycle(0, 1, 0, 8'h80);
    write_fields(y, mo, d, dw, h, mi, s);
    cycle(0, 1, 0, 8'h00);
  endtask

  task automatic one_sec(input string tag, input int y, input int mo, input int d,
                         input int dw, input int h, input int mi, input int s);
    set_time(y, mo, d, dw, h, mi, s);
    run(SECOND);
    idle(2);
    check_time(tag);
  endtask

  initial begin : watchdog
    repeat (195000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin : main
    logic [7:0] v, fz [1:7];
    int unsigned seed;
    seed = $urandom(32'd7361);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset values and window decode; R12 control readback
    check_time("R1 reset");
    rd(0, v); chk("R12 reset ctrl", v, 8'h00);
    read_at(11'h000, v); chk("R1 outside window", v, 8'h00);
    addr = 11'h7F6; ce_n = 1'b0; oe_n = 1'b0; #1; v = dq_out; ce_n = 1'b1; oe_n = 1'b1;
    chk("R1 below window", v, 8'h00);
    addr = 11'h7FC; ce_n = 1'b0; oe_n = 1'b1; #1; v = dq_out; ce_n = 1'b1;
    chk("R1 oe_n high", v, 8'h00);

    // R2 one second per full prescaler period
    run(SECOND - 1); idle(2);
    rd(1, v); chk("R2 before period", v, 8'h00);
    run(1); idle(2);
    rd(1, v); chk("R2 after period", v, 8'h01);
    one_sec("R2 bcd digit", 5, 3, 14, 2, 8, 30, 9);

    // R3 carries
    one_sec("R3 minute carry", 21, 6, 15, 3, 10, 59, 59);
    one_sec("R3 day carry dow7", 21, 6, 15, 7, 23, 59, 59);

    // R4 month lengths and leap years
    one_sec("R4 feb28 y03", 3, 2, 28, 1, 23, 59, 59);
    one_sec("R4 feb28 y04", 4, 2, 28, 1, 23, 59, 59);
    one_sec("R4 feb29 y00", 0, 2, 29, 2, 23, 59, 59);
    one_sec("R4 apr30", 22, 4, 30, 5, 23, 59, 59);
    one_sec("R4 jan31", 22, 1, 31, 5, 23, 59, 59);
    one_sec("R4 year 99", 99, 12, 31, 6, 23, 59, 59);

    // R3 R4 random dates biased toward carries
    for (int k = 0; k < 14; k++) begin
      int y, mo, d, h, mi, s, dw;
      y  = $urandom % 100;
      mo = 1 + $urandom % 12;
      d  = ($urandom % 2) ? days_of(mo, y) : 1 + $urandom % days_of(mo, y);
      dw = 1 + $urandom % 7;
      h  = ($urandom % 2) ? 23 : $urandom % 24;
      mi = ($urandom % 4 != 0) ? 59 : $urandom % 60;
      s  = ($urandom % 4 != 0) ? 59 : $urandom % 60;
      one_sec("R4 random", y, mo, d, dw, h, mi, s);
    end

    // R5 freeze while counters run; R6 resync
    set_time(10, 7, 4, 3, 12, 0, 58);
    run(SECOND / 2);
    cycle(0, 1, 0, 8'h40);
    for (int i = 1; i <= 7; i++) fz[i] = model_field(i);
    rd(0, v); chk("R12 read bit", v, 8'h40);
    run(3 * SECOND); idle(2);
    rd(1, v); chk("R5 frozen sec", v, fz[1]);
    rd(2, v); chk("R5 frozen min", v, fz[2]);
    rd(7, v); chk("R5 frozen year", v, fz[7]);
    cycle(0, 1, 0, 8'h00);
    idle(2);
    check_time("R6 resync");
    rd(1, v); chk("R5 counters advanced", v, 8'h01);

    // R7 masking while held, ignored when not held
    cycle(0, 1, 0, 8'h80);
    rd(0, v); chk("R12 write bit", v, 8'h80);
    cycle(0, 1, 2, 8'hFF); rd(2, v); chk("R7 min mask", v, 8'h7F);
    cycle(0, 1, 3, 8'hFF); rd(3, v); chk("R7 hour mask", v, 8'h3F);
    cycle(0, 1, 6, 8'hFF); rd(6, v); chk("R7 month mask", v, 8'h1F);
    write_fields(45, 9, 9, 4, 9, 9, 9);
    rd(5, v); chk("R7 date held", v, 8'h09);
    cycle(0, 1, 0, 8'h00);
    idle(2);
    check_time("R8 loaded");
    cycle(0, 1, 2, 8'h33); idle(2);
    rd(2, v); chk("R7 ignored min", v, to_bcd(m_min));
    cycle(0, 1, 7, 8'h77); idle(2);
    rd(7, v); chk("R7 ignored year", v, 8'h45);

    // R8 load restarts the prescaler
    run(1000);
    set_time(30, 5, 20, 2, 6, 15, 0);
    run(SECOND - 1); idle(2);
    rd(1, v); chk("R8 no early second", v, 8'h00);
    run(1); idle(2);
    rd(1, v); chk("R8 second after full period", v, 8'h01);

    // R9 load and second event in one cycle
    set_time(30, 5, 20, 2, 6, 15, 0);
    cycle(0, 1, 0, 8'h80);
    write_fields(31, 8, 8, 5, 20, 40, 10);
    for (int i = 0; i < SECOND - 1; i++) cycle(1, 0, 0, 8'h00);
    cycle(1, 1, 0, 8'h00);
    idle(2);
    rd(1, v); chk("R9 load wins sec", v, 8'h10);
    check_time("R9 loaded time");
    run(SECOND); idle(2);
    rd(1, v); chk("R9 next second", v, 8'h11);

    // R10 oscillator stop
    cycle(0, 1, 1, 8'h80);
    rd(1, v); chk("R10 stop bit readback", v, 8'h91);
    run(2 * SECOND); idle(2);
    check_time("R10 halted");
    rd(1, v); chk("R10 no time passed", v, 8'h91);
    cycle(0, 1, 1, 8'h00);
    run(SECOND); idle(2);
    rd(1, v); chk("R10 resumed", v, 8'h12);

    // R11 frequency test
    set_time(12, 3, 3, 1, 1, 1, 20);
    cycle(0, 1, 4, 8'h41);
    rd(4, v); chk("R11 test bit readback", v, 8'h41);
    for (int i = 0; i < 120; i++) begin
      cycle(1, 0, 0, 8'h00);
      rd(1, v);
      chk("R11 toggle", v, {1'b0, 6'h10, 1'((presc >> (PW - 10)) & 1)});
    end
    cycle(0, 1, 1, 8'h80);
    rd(1, v); chk("R11 stopped normal lsb", v, 8'hA0);
    cycle(0, 1, 1, 8'h00);
    cycle(0, 1, 4, 8'h01);
    idle(2);
    check_time("R11 test off");

    // R12 reserved control bits
    cycle(0, 1, 0, 8'hFF);
    rd(0, v); chk("R12 reserved zero", v, 8'hC0);
    cycle(0, 1, 0, 8'h00);
    idle(2);
    check_time("R12 after clear");

    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule